// File: doc/BRIEF.md
# Energy Efficient Ethernet Low-Power Idle Controller

This block decides when the transmit side of an Ethernet MAC may drop into low-power idle and when it may send frames again. Software programs two guard times and a handful of control bits through a two-register interface. The block watches three inputs: a frame-pending indication from the MAC, a link-status pin from the PHY and a receive-side low-power detect. From these it drives an LPI request to the transmit datapath, an optional transmit clock-gate enable and an interrupt.

Entry into low-power idle needs three things: the link must have been good without a break for longer than the programmed link-stable time, counted in milliseconds, the block must be enabled, and no frame may be pending. After the block leaves low-power idle, the frame-ready handshake stays low for the programmed wake time, counted in microseconds. Only then can normal frames flow again. Both time units come from the core clock through a parameterised prescaler. Entry and exit on the transmit side and on the receive side are recorded in sticky flags. The interrupt is raised while any flag is set, and reading the control/status register clears the flags.

Top module: `eee_lpi_ctl`

## Requirements
- R1: After reset, lpi_req, clk_gate_en and irq are 0, frm_ready is 1, and both registers read as zero.
- R2: Register address 0 is control/status, with fields lpi_en bit 0, auto_wake bit 1, gate_en bit 2, link_sw bit 3, flags tx_entry bit 8, tx_exit bit 9, rx_entry bit 10, rx_exit bit 11, transmit-in-LPI bit 16 and receive-in-LPI bit 17. Register address 1 is the timer register, with the wake time TW in bits 15:0 and the link-stable time LS in bits 25:16. Unlisted bits read 0.
- R3: lpi_req rises only when lpi_en is set, tx_req is low, and link good (phy_link and link_sw both 1) has held without a break for at least LS ms and at most LS+1 ms plus three cycles. One ms is US_PER_MS × CLK_PER_US clock cycles.
- R4: While in LPI with auto_wake set, a pending frame (tx_req high) ends LPI on the next cycle. With auto_wake clear, LPI holds and frm_ready stays low while tx_req waits.
- R5: Clearing lpi_en, with or without auto_wake, ends LPI on the next cycle, and LPI is not re-entered while lpi_en stays clear.
- R6: If link good drops while in LPI, lpi_req falls on the next cycle and the link-stable time restarts from zero.
- R7: After lpi_req falls, frm_ready stays low for at least TW µs and at most TW+1 µs plus two cycles (one µs is CLK_PER_US cycles). frm_ready is never high while lpi_req is high.
- R8: clk_gate_en is high exactly when lpi_req is high and gate_en is set.
- R9: The tx_entry flag sets when LPI is entered, and the tx_exit flag sets when LPI is left.
- R10: The rx_entry flag sets on a rising edge of rx_lpi, the rx_exit flag sets on a falling edge, and bit 17 follows rx_lpi one cycle late.
- R11: irq is high while any flag is set. A read of the control/status register returns the flags and clears them and irq on the next cycle, unless a new event arrives in that same cycle. A read of the timer register clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears flags on address 0) |
| reg_addr | input | 1 | 0 control/status, 1 timer |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| tx_req | input | 1 | MAC has a frame to send; low means transmit idle |
| frm_ready | output | 1 | Frames may be sent |
| phy_link | input | 1 | Link status from the PHY |
| rx_lpi | input | 1 | Receive path detects LPI |
| lpi_req | output | 1 | Request LPI signalling on the transmit datapath |
| clk_gate_en | output | 1 | Transmit clock may be gated |
| irq | output | 1 | Any status flag pending |

## Verification
The bench builds the block with CLK_PER_US = 2 and US_PER_MS = 4, so a millisecond is 8 cycles. This lets every link-stable setting from 0 to 3 and every wake setting from 0 to 5 be swept in full, each within a few dozen cycles. The prescaler runs freely, so each guard delay lands somewhere inside a one-tick window. The bench checks the measured delay against both ends of that window, worked out from LS and TW. The rarer orderings are also reached directly at this scale: a link drop during LPI, a frame held in manual mode, and an event in the same cycle as a read.

// File: rtl/lpi_pkg.sv
package lpi_pkg;
    localparam int REG_W    = 32;
    localparam int TW_W     = 16;
    localparam int LS_W     = 10;
    localparam int LS_LSB   = 16;
    localparam int CTRL_W   = 4;
    localparam int FLAG_LSB = 8;
    localparam int FLAG_W   = 4;
    localparam int TXST_BIT = 16;
    localparam int RXST_BIT = 17;
    localparam logic REG_CSR = 1'b0;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_LPI  = 2'd1,
        ST_WAKE = 2'd2
    } lpi_state_e;

    typedef struct packed {
        logic link_sw;
        logic gate_en;
        logic auto_wake;
        logic lpi_en;
    } lpi_ctrl_t;

    typedef struct packed {
        logic rx_exit;
        logic rx_entry;
        logic tx_exit;
        logic tx_entry;
    } lpi_flags_t;

    typedef struct packed {
        lpi_state_e        st;
        lpi_ctrl_t         ctrl;
        logic [LS_W-1:0]   ls;
        logic [TW_W-1:0]   tw;
        lpi_flags_t        flags;
        logic              rx_q;
    } lpi_core_t;
endpackage

// File: rtl/lpi_tick_gen.sv
module lpi_tick_gen #(
    parameter int CLK_PER_US = 125,
    parameter int US_PER_MS  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic us_tick,
    output logic ms_tick
);
    localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam int UW = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [UW-1:0] us;
    } tick_t;

    tick_t t_q, t_d;

    always_comb begin
        t_d     = t_q;
        us_tick = (t_q.pre == PW'(CLK_PER_US - 1));
        ms_tick = us_tick && (t_q.us == UW'(US_PER_MS - 1));
        t_d.pre = us_tick ? '0 : t_q.pre + 1'b1;
        if (us_tick) begin
            t_d.us = ms_tick ? '0 : t_q.us + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/lpi_guard_cnt.sv
module lpi_guard_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W:0] cnt_q, cnt_d;

    // done once more than limit ticks were seen, so a full limit period elapsed
    always_comb begin
        done  = cnt_q > {1'b0, limit};
        cnt_d = cnt_q;
        if (clr)                cnt_d = '0;
        else if (tick && !done) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/eee_lpi_ctl.sv
module eee_lpi_ctl
    import lpi_pkg::*;
#(
    parameter int CLK_PER_US = 125,
    parameter int US_PER_MS  = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             tx_req,
    output logic             frm_ready,
    input  logic             phy_link,
    input  logic             rx_lpi,
    output logic             lpi_req,
    output logic             clk_gate_en,
    output logic             irq
);
    lpi_core_t r_q, r_d;

    logic us_tick, ms_tick, ls_done, tw_done;
    logic link_good, go_lpi, leave_lpi, csr_rd;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata[REG_W-1:LS_LSB+LS_W];
    assign link_good    = phy_link & r_q.ctrl.link_sw;

    lpi_tick_gen #(.CLK_PER_US(CLK_PER_US), .US_PER_MS(US_PER_MS)) u_tick (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .ms_tick(ms_tick)
    );

    lpi_guard_cnt #(.W(LS_W)) u_ls (
        .clk(clk), .rst_n(rst_n), .clr(!link_good), .tick(ms_tick),
        .limit(r_q.ls), .done(ls_done)
    );

    lpi_guard_cnt #(.W(TW_W)) u_tw (
        .clk(clk), .rst_n(rst_n), .clr(r_q.st != ST_WAKE), .tick(us_tick),
        .limit(r_q.tw), .done(tw_done)
    );

    always_comb begin
        r_d       = r_q;
        go_lpi    = 1'b0;
        leave_lpi = 1'b0;
        csr_rd    = reg_rd && (reg_addr == REG_CSR);

        if (reg_wr && reg_addr == REG_CSR) begin
            r_d.ctrl = lpi_ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end
        if (reg_wr && reg_addr != REG_CSR) begin
            r_d.tw = reg_wdata[TW_W-1:0];
            r_d.ls = reg_wdata[LS_LSB +: LS_W];
        end

        unique case (r_q.st)
            ST_RUN: begin
                if (r_q.ctrl.lpi_en && link_good && ls_done && !tx_req) begin
                    r_d.st = ST_LPI;
                    go_lpi = 1'b1;
                end
            end
            ST_LPI: begin
                if (!r_q.ctrl.lpi_en || !link_good || (r_q.ctrl.auto_wake && tx_req)) begin
                    r_d.st    = ST_WAKE;
                    leave_lpi = 1'b1;
                end
            end
            ST_WAKE: begin
                if (tw_done) r_d.st = ST_RUN;
            end
            default: r_d.st = ST_RUN;
        endcase

        r_d.rx_q = rx_lpi;
        if (csr_rd) r_d.flags = '0;
        r_d.flags.tx_entry = r_d.flags.tx_entry | go_lpi;
        r_d.flags.tx_exit  = r_d.flags.tx_exit  | leave_lpi;
        r_d.flags.rx_entry = r_d.flags.rx_entry | (rx_lpi & ~r_q.rx_q);
        r_d.flags.rx_exit  = r_d.flags.rx_exit  | (~rx_lpi & r_q.rx_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        lpi_req     = (r_q.st == ST_LPI);
        frm_ready   = (r_q.st == ST_RUN);
        clk_gate_en = lpi_req & r_q.ctrl.gate_en;
        irq         = |r_q.flags;
        reg_rdata   = '0;
        if (reg_addr == REG_CSR) begin
            reg_rdata[CTRL_W-1:0]          = r_q.ctrl;
            reg_rdata[FLAG_LSB +: FLAG_W]  = r_q.flags;
            reg_rdata[TXST_BIT]            = lpi_req;
            reg_rdata[RXST_BIT]            = r_q.rx_q;
        end else begin
            reg_rdata[TW_W-1:0]            = r_q.tw;
            reg_rdata[LS_LSB +: LS_W]      = r_q.ls;
        end
    end
endmodule

// File: rtl/eee_lpi_ctl_chk.sv
module eee_lpi_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic phy_link,
    input logic tx_req,
    input logic lpi_req,
    input logic frm_ready,
    input logic clk_gate_en
);
    // R7
    no_ready_in_lpi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lpi_req && frm_ready));

    // R7
    wake_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lpi_req) |-> !frm_ready);

    // R7
    resume_via_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frm_ready) |-> !$past(lpi_req));

    // R8
    gate_only_in_lpi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_gate_en |-> lpi_req);

    // R6
    link_drop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lpi_req && !phy_link) |=> !lpi_req);

    // R3
    entry_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lpi_req) |-> ($past(phy_link) && !$past(tx_req)));
endmodule

bind eee_lpi_ctl eee_lpi_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .phy_link(phy_link), .tx_req(tx_req),
    .lpi_req(lpi_req), .frm_ready(frm_ready), .clk_gate_en(clk_gate_en)
);

// File: tb/eee_lpi_ctl_bench.sv
module eee_lpi_ctl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int P = 2;
    localparam int U = 4;
    localparam int M = P * U;
    localparam logic [31:0] EN = 32'h1, AUTO = 32'h2, GATE = 32'h4, LSW = 32'h8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 0, reg_rd = 0, reg_addr = 0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic tx_req = 0, phy_link = 0, rx_lpi = 0;
    logic frm_ready, lpi_req, clk_gate_en, irq;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eee_lpi_ctl #(.CLK_PER_US(P), .US_PER_MS(U)) u_eee_lpi_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_req(tx_req), .frm_ready(frm_ready), .phy_link(phy_link),
        .rx_lpi(rx_lpi), .lpi_req(lpi_req), .clk_gate_en(clk_gate_en), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0; reg_addr = 0;
    endtask

    task automatic wait_lpi(output int n);
        n = 0;
        while (!lpi_req && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_ready();
        int k = 0;
        while (!frm_ready && k < 1000) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk(lpi_req == 0 && clk_gate_en == 0 && irq == 0, "R1 outputs", {lpi_req, clk_gate_en, irq}, 0);
        chk(frm_ready == 1, "R1 frm_ready", frm_ready, 1);
        rd(1'b0, d); chk(d == 0, "R1 csr", d, 0);
        rd(1'b1, d); chk(d == 0, "R1 timer", d, 0);

        // R2 field positions
        wr(1'b1, {6'h3F, 10'h2A5, 16'hBEEF});
        rd(1'b1, d); chk(d == 32'h02A5BEEF, "R2 timer fields", d, 32'h02A5BEEF);
        wr(1'b1, 32'hFFFFFFFF);
        rd(1'b1, d); chk(d == 32'h03FFFFFF, "R2 timer width", d, 32'h03FFFFFF);
        wr(1'b0, 32'hFFFF_FFFF & ~EN);
        rd(1'b0, d); chk(d == 32'h0000000E, "R2 csr ctrl bits", d, 32'hE);

        // R3 no entry without lpi_en, without link_sw, or with tx_req
        phy_link = 1;
        wr(1'b1, 32'h0);
        wr(1'b0, LSW | AUTO);
        repeat (3*M) @(negedge clk);
        chk(lpi_req == 0, "R3 no entry lpi_en clear", lpi_req, 0);
        wr(1'b0, EN | AUTO);
        repeat (3*M) @(negedge clk);
        chk(lpi_req == 0, "R3 no entry link_sw clear", lpi_req, 0);
        tx_req = 1;
        wr(1'b0, LSW | EN);
        repeat (3*M) @(negedge clk);
        chk(lpi_req == 0, "R3 no entry while tx_req", lpi_req, 0);
        tx_req = 0;
        @(negedge clk); @(negedge clk);
        chk(lpi_req == 1, "R3 entry after idle", lpi_req, 1);
        wr(1'b0, LSW);
        wait_ready();

        // R3 link-stable sweep
        for (int ls = 0; ls < 4; ls++) begin
            phy_link = 0;
            wr(1'b1, (32'(ls) << 16) | 32'd1);
            wr(1'b0, LSW | EN);
            repeat (3) @(negedge clk);
            chk(lpi_req == 0, "R3 no entry link down", lpi_req, 0);
            phy_link = 1;
            wait_lpi(n);
            chk(n >= ls*M + 1 && n <= (ls+1)*M + 3, "R3 link-stable delay", n, ls*M + 1);
            wr(1'b0, LSW);
            wait_ready();
        end

        // R7 / R4 wake sweep with auto_wake
        wr(1'b1, 32'd0);
        wr(1'b0, LSW | EN | AUTO);
        for (int tw = 0; tw < 6; tw++) begin
            int cnt;
            wr(1'b1, 32'(tw));
            wait_lpi(n);
            chk(lpi_req == 1, "R4 in LPI before frame", lpi_req, 1);
            tx_req = 1;
            @(negedge clk);
            chk(lpi_req == 0, "R4 frame ends LPI", lpi_req, 0);
            cnt = 0;
            while (!frm_ready && cnt < 1000) begin
                cnt++;
                @(negedge clk);
            end
            chk(cnt >= tw*P + 1 && cnt <= (tw+1)*P + 2, "R7 wake gap", cnt, tw*P + 1);
            repeat (2) @(negedge clk);
            chk(lpi_req == 0 && frm_ready == 1, "R7 resumed", {lpi_req, frm_ready}, 1);
            tx_req = 0;
        end

        // R4 manual mode holds LPI
        wr(1'b0, LSW | EN);
        wait_lpi(n);
        tx_req = 1;
        repeat (20) @(negedge clk);
        chk(lpi_req == 1 && frm_ready == 0, "R4 manual hold", {lpi_req, frm_ready}, 2);
        wr(1'b0, LSW | EN | AUTO);
        @(negedge clk);
        chk(lpi_req == 0, "R4 auto_wake releases", lpi_req, 0);
        wait_ready();
        tx_req = 0;

        // R5 clearing enables ends LPI
        wait_lpi(n);
        wr(1'b0, LSW);
        @(negedge clk);
        chk(lpi_req == 0, "R5 exit on disable", lpi_req, 0);
        repeat (3*M) @(negedge clk);
        chk(lpi_req == 0, "R5 no re-entry", lpi_req, 0);

        // R6 link drop restarts link-stable time
        wr(1'b1, 32'd2 << 16);
        wr(1'b0, LSW | EN | AUTO);
        wait_lpi(n);
        phy_link = 0;
        @(negedge clk);
        chk(lpi_req == 0, "R6 drop exits", lpi_req, 0);
        repeat (5) @(negedge clk);
        phy_link = 1;
        wait_lpi(n);
        chk(n >= 2*M + 1 && n <= 3*M + 3, "R6 restart delay", n, 2*M + 1);

        // R8 clock gate
        wr(1'b1, 32'd0);
        wr(1'b0, LSW | EN | GATE);
        wait_lpi(n);
        @(negedge clk);
        chk(clk_gate_en == 1, "R8 gate in LPI", clk_gate_en, 1);
        wr(1'b0, LSW | EN);
        chk(clk_gate_en == 0 && lpi_req == 1, "R8 gate off", {clk_gate_en, lpi_req}, 1);

        // R9 / R11 flags and clear-on-read
        rd(1'b0, d);
        chk(irq == 0, "R11 irq cleared", irq, 0);
        wr(1'b0, LSW);
        repeat (2) @(negedge clk);
        chk(irq == 1, "R11 irq on exit", irq, 1);
        rd(1'b0, d);
        chk(d[11:8] == 4'b0010, "R9 tx_exit flag", d[11:8], 2);
        chk(irq == 0, "R11 read clears", irq, 0);
        wr(1'b0, LSW | EN);
        wait_lpi(n);
        @(negedge clk);
        rd(1'b1, d);
        chk(irq == 1, "R11 timer read keeps irq", irq, 1);
        rd(1'b0, d);
        chk(d[11:8] == 4'b0001 && d[16] == 1, "R9 tx_entry flag", {d[16], d[11:8]}, 17);
        chk(irq == 0, "R11 irq low after read", irq, 0);

        // R10 receive flags
        rx_lpi = 1;
        repeat (2) @(negedge clk);
        rd(1'b0, d);
        chk(d[11:8] == 4'b0100 && d[17] == 1, "R10 rx_entry", {d[17], d[11:8]}, 20);
        rx_lpi = 0;
        repeat (2) @(negedge clk);
        chk(irq == 1, "R11 irq on rx exit", irq, 1);
        rd(1'b0, d);
        chk(d[11:8] == 4'b1000 && d[17] == 0, "R10 rx_exit", {d[17], d[11:8]}, 8);

        // R11 event in same cycle as read survives
        @(negedge clk);
        reg_rd = 1; reg_addr = 0; rx_lpi = 1;
        @(negedge clk);
        reg_rd = 0;
        chk(irq == 1, "R11 same-cycle event kept", irq, 1);
        rd(1'b0, d);
        chk(d[10] == 1, "R10 rx_entry kept", d[10], 1);

        finished = 1;
        summary();
        $finish;
    end
endmodule